// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable stand-in for a small serial EEPROM that is reached over a chip-select, a shift clock, a serial data input and a serial data output. The system clock runs much faster than the shift clock. The block synchronizes the serial pins into the system clock domain and finds shift-clock rising edges there. It keeps its storage in a register-file array of bytes. A strap input picks between two organizations. One is 64 words of 16 bits with a 6-bit address. The other is 128 bytes with a 7-bit address.

Each command opens with a 1 start bit on the input line. A two-bit opcode follows, and then the address. Reads return a leading 0 and then the stored word. Programming commands are held back by a write-enable latch, and they occupy the block for a fixed number of system clocks. While that programming interval runs, the block ignores new commands. When the host selects the block again, the output line reports busy or ready. A tristate-enable output marks the times the output pin is driven.

Top module: `serial_nvm_slave`

## Requirements
- R1: After reset the write-enable latch is clear and every stored bit is 1. `dout_en` is 0 whenever `cs` is low.
- R2: A frame is a start bit of 1, a 2-bit opcode and an address, each sent MSB first and sampled on rising `sk` edges while `cs` is high. Zeros that come before the start bit are ignored. The address is 6 bits when `wide_org`=1 and 7 bits when `wide_org`=0.
- R3: Opcode 10 (read) drives a dummy 0 on `dout` at the `sk` edge that takes the last address bit. Each later rising edge then drives the next data bit, MSB first: 16 bits in wide mode and 8 bits in byte mode. Reads work whether or not programming is enabled.
- R4: Opcode 01 (write) is followed by 16 data bits in wide mode or 8 data bits in byte mode, and it replaces the addressed entry. Wide word `a` is stored in byte `2a+1` (upper half) and byte `2a` (lower half), so each byte can be read back in byte mode.
- R5: Opcode 11 (erase) sets every bit of the addressed entry to 1.
- R6: For opcode 00, the two most significant address bits select the action. 11 enables programming, 00 disables it, 10 sets the whole array to 1, and 01 is followed by a data word that is written to every entry.
- R7: Write, erase, fill-ones and fill-data have no effect while the write-enable latch is clear. The latch stays set from an enable until a disable.
- R8: A programming interval of `PROG_CYCLES` system clocks starts after the last data bit for write and fill-data, and after the last address bit for erase and fill-ones.
- R9: If `cs` is raised during a programming interval, `dout` is driven 0 while the interval runs and 1 once it ends, until `cs` falls. If `cs` is raised only after the interval has ended, `dout` stays undriven.
- R10: A start bit that arrives during a programming interval is ignored, together with the rest of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sk` |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial shift clock |
| di | input | 1 | Serial command, address and data input |
| wide_org | input | 1 | 1 selects 64 x 16, 0 selects 128 x 8 |
| dout | output | 1 | Serial read data or busy/ready status |
| dout_en | output | 1 | 1 while `dout` is driven; 0 models high impedance |

## Verification
The read path is exercised with an erased array, with mixed-bit patterns in a low and in the top word, and with zeros padded before the start bit. Together these show the dummy bit, the bit order and the address length. A word is written in wide mode and then read back byte by byte in byte mode, and a byte is written and read back as a word. These cases pin down the byte placement that the two organizations share. Programming commands are sent with the latch clear, after enable and after disable, which separates gated from executed operations. Status is sampled inside the interval, after it, and when the host selects late, and a full write frame is sent during busy, which shows that busy frames are dropped.

// File: rtl/snvm_pkg.sv
package snvm_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_READ,
        ST_DONE
    } fsm_t;

    typedef enum logic [1:0] {
        OPC_EXT   = 2'b00,
        OPC_WRITE = 2'b01,
        OPC_READ  = 2'b10,
        OPC_ERASE = 2'b11
    } opc_t;

    // sub-actions of opcode 00, chosen by the two top address bits
    typedef enum logic [1:0] {
        EXT_LOCK   = 2'b00,
        EXT_FILLW  = 2'b01,
        EXT_FILL1  = 2'b10,
        EXT_UNLOCK = 2'b11
    } ext_t;

    typedef enum logic [1:0] {
        PK_NONE,
        PK_WORD,
        PK_ALL
    } pkind_t;

    typedef struct packed {
        pkind_t              kind;
        logic                wide;
        logic [WORD_W-1:0]   data;
    } prog_req_t;

    function automatic ext_t ext_decode(input logic [1:0] top2);
        return ext_t'(top2);
    endfunction

endpackage

// File: rtl/snvm_sync.sv
module snvm_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins_in,
    output logic [W-1:0] pins_q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= pins_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign pins_q = chain[STAGES-1];
endmodule

// File: rtl/snvm_busy_timer.sv
module snvm_busy_timer #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int TW = $clog2(CYCLES + 1);

    logic [TW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)                remain <= '0;
        else if (start)         remain <= TW'(CYCLES);
        else if (remain != '0)  remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);

    // R8: a programming interval is under way one clock after its start
    a_r8_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);
endmodule

// File: rtl/snvm_array.sv
module snvm_array
    import snvm_pkg::*;
#(
    parameter int WADDR_W = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  prog_req_t            req,
    input  logic [WADDR_W:0]     req_addr,
    input  logic                 rd_wide,
    input  logic [WADDR_W:0]     rd_addr,
    output logic [WORD_W-1:0]    rd_word
);
    localparam int BADDR_W = WADDR_W + 1;
    localparam int BYTES   = 2 ** BADDR_W;

    logic [7:0] mem [BYTES];

    for (genvar i = 0; i < BYTES; i++) begin : g_byte
        localparam logic [BADDR_W-1:0] IDX = BADDR_W'(i);
        logic       hit;
        logic [7:0] nval;

        always_comb begin
            if (req.wide) begin
                hit  = (IDX[BADDR_W-1:1] == req_addr[WADDR_W-1:0]);
                nval = IDX[0] ? req.data[15:8] : req.data[7:0];
            end else begin
                hit  = (IDX == req_addr);
                nval = req.data[7:0];
            end
        end

        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= 8'hFF;
            else if (req.kind == PK_ALL || (req.kind == PK_WORD && hit))
                mem[i] <= nval;
        end
    end

    always_comb begin
        if (rd_wide)
            rd_word = {mem[{rd_addr[WADDR_W-1:0], 1'b1}], mem[{rd_addr[WADDR_W-1:0], 1'b0}]};
        else
            rd_word = {mem[rd_addr], 8'h00};
    end

    // R6: a fill of the array reaches the last byte
    a_r6_fill_reaches_top: assert property (@(posedge clk) disable iff (rst)
        (req.kind == PK_ALL) |=>
            mem[BYTES-1] == $past(req.wide ? req.data[15:8] : req.data[7:0]));
endmodule

// File: rtl/serial_nvm_slave.sv
module serial_nvm_slave
    import snvm_pkg::*;
#(
    parameter int WADDR_W     = 6,
    parameter int PROG_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic cs,
    input  logic sk,
    input  logic di,
    input  logic wide_org,
    output logic dout,
    output logic dout_en
);
    localparam int BADDR_W = WADDR_W + 1;
    localparam int CNT_W   = $clog2(WORD_W + 1);

    // synchronized pins
    logic [2:0] pins_q;
    logic       cs_s, sk_s, di_s, sk_prev, sk_rise;

    snvm_sync #(.W(3), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pins_in ({cs, sk, di}),
        .pins_q  (pins_q)
    );

    assign {cs_s, sk_s, di_s} = pins_q;

    always_ff @(posedge clk) begin
        if (rst) sk_prev <= 1'b0;
        else     sk_prev <= sk_s;
    end
    assign sk_rise = sk_s & ~sk_prev;

    // command state
    fsm_t                 state;
    opc_t                 opc_q;
    logic [CNT_W-1:0]     cnt;
    logic [BADDR_W-1:0]   addr_sh;
    logic [WORD_W-1:0]    data_sh;
    logic [WORD_W-1:0]    rd_sh;
    logic                 rd_active, rd_bit;
    logic                 wen_q;
    logic                 status_pend;
    prog_req_t            req;
    logic [BADDR_W-1:0]   req_addr;
    logic                 busy;

    logic [BADDR_W-1:0]   addr_nxt;
    logic [WORD_W-1:0]    data_nxt;
    logic [WORD_W-1:0]    rd_word;
    logic [CNT_W-1:0]     alen_m1, dlen;
    logic [1:0]           top2;

    assign addr_nxt = {addr_sh[BADDR_W-2:0], di_s};
    assign data_nxt = {data_sh[WORD_W-2:0], di_s};
    assign alen_m1  = wide_org ? CNT_W'(WADDR_W - 1) : CNT_W'(WADDR_W);
    assign dlen     = wide_org ? CNT_W'(WORD_W) : CNT_W'(WORD_W / 2);
    assign top2     = wide_org ? addr_nxt[WADDR_W-1 -: 2] : addr_nxt[WADDR_W -: 2];

    snvm_array #(.WADDR_W(WADDR_W)) u_array (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .req_addr (req_addr),
        .rd_wide  (wide_org),
        .rd_addr  (addr_nxt),
        .rd_word  (rd_word)
    );

    snvm_busy_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (req.kind != PK_NONE),
        .busy  (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            opc_q       <= OPC_EXT;
            cnt         <= '0;
            addr_sh     <= '0;
            data_sh     <= '0;
            rd_sh       <= '0;
            rd_active   <= 1'b0;
            rd_bit      <= 1'b0;
            wen_q       <= 1'b0;
            status_pend <= 1'b0;
            req         <= '{kind: PK_NONE, wide: 1'b0, data: '0};
            req_addr    <= '0;
        end else begin
            req.kind <= PK_NONE;
            if (!cs_s) begin
                state     <= ST_IDLE;
                rd_active <= 1'b0;
                if (!busy) status_pend <= 1'b0;
            end else if (sk_rise) begin
                unique case (state)
                    ST_IDLE: begin
                        if (di_s && !busy) begin
                            state       <= ST_OPC;
                            cnt         <= '0;
                            status_pend <= 1'b0;
                        end
                    end
                    ST_OPC: begin
                        opc_q <= opc_t'({opc_q[0], di_s});
                        if (cnt == CNT_W'(1)) begin
                            state   <= ST_ADDR;
                            cnt     <= '0;
                            addr_sh <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_ADDR: begin
                        addr_sh <= addr_nxt;
                        cnt     <= cnt + 1'b1;
                        if (cnt == alen_m1) begin
                            cnt   <= '0;
                            state <= ST_DONE;
                            unique case (opc_q)
                                OPC_READ: begin
                                    rd_sh     <= rd_word;
                                    rd_active <= 1'b1;
                                    rd_bit    <= 1'b0;
                                    state     <= ST_READ;
                                end
                                OPC_WRITE: state <= ST_DATA;
                                OPC_ERASE: begin
                                    if (wen_q) begin
                                        req         <= '{kind: PK_WORD, wide: wide_org, data: '1};
                                        req_addr    <= addr_nxt;
                                        status_pend <= 1'b1;
                                    end
                                end
                                OPC_EXT: begin
                                    unique case (ext_decode(top2))
                                        EXT_UNLOCK: wen_q <= 1'b1;
                                        EXT_LOCK:   wen_q <= 1'b0;
                                        EXT_FILL1: begin
                                            if (wen_q) begin
                                                req         <= '{kind: PK_ALL, wide: wide_org, data: '1};
                                                req_addr    <= addr_nxt;
                                                status_pend <= 1'b1;
                                            end
                                        end
                                        EXT_FILLW: state <= ST_DATA;
                                    endcase
                                end
                            endcase
                        end
                    end
                    ST_DATA: begin
                        data_sh <= data_nxt;
                        cnt     <= cnt + 1'b1;
                        if (cnt == dlen - 1'b1) begin
                            state <= ST_DONE;
                            if (wen_q) begin
                                req.kind    <= (opc_q == OPC_WRITE) ? PK_WORD : PK_ALL;
                                req.wide    <= wide_org;
                                req.data    <= data_nxt;
                                req_addr    <= addr_sh;
                                status_pend <= 1'b1;
                            end
                        end
                    end
                    ST_READ: begin
                        if (cnt == dlen) begin
                            rd_active <= 1'b0;
                            state     <= ST_DONE;
                        end else begin
                            rd_bit <= rd_sh[WORD_W-1];
                            rd_sh  <= {rd_sh[WORD_W-2:0], 1'b0};
                            cnt    <= cnt + 1'b1;
                        end
                    end
                    ST_DONE: ;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign dout_en = cs_s && (rd_active || (status_pend && state == ST_IDLE));
    assign dout    = rd_active ? rd_bit : ~busy;

    // R1: read data is not held once the select has been low for two clocks
    a_r1_no_read_after_deselect: assert property (@(posedge clk) disable iff (rst)
        (!cs_s && $past(!cs_s)) |-> !rd_active);

    // R3: the first driven read bit is the dummy zero
    a_r3_dummy_first: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_active) |-> !rd_bit);

    // R7: no programming is requested while the latch is clear
    a_r7_locked_no_program: assert property (@(posedge clk) disable iff (rst)
        !wen_q |-> req.kind == PK_NONE);

    // R10: no programming is requested during a running interval
    a_r10_busy_no_program: assert property (@(posedge clk) disable iff (rst)
        busy |-> req.kind == PK_NONE);
endmodule

// File: tb/test_serial_nvm_slave.sv
module test_serial_nvm_slave;
    localparam int PROG = 1500;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0, wide = 1'b1;
    logic dout, dout_en;

    always #10 clk = ~clk;

    serial_nvm_slave #(.WADDR_W(6), .PROG_CYCLES(PROG)) i_serial_nvm_slave (
        .clk(clk), .rst(rst), .cs(cs), .sk(sk), .di(di),
        .wide_org(wide), .dout(dout), .dout_en(dout_en)
    );

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    bit    q_en[$];
    bit    q_val[$];
    string q_tag[$];
    event  smp_ev;

    // monitor: pops the expected item and compares with the pins
    initial begin
        forever begin
            @(smp_ev);
            if (q_en.size() != 0) begin
                bit e_en, e_val;
                string tg;
                e_en  = q_en.pop_front();
                e_val = q_val.pop_front();
                tg    = q_tag.pop_front();
                compared++;
                if (dout_en !== e_en || (e_en && dout !== e_val)) begin
                    mismatched++;
                    $display("FAIL %s: en/dout=%b/%b expected %b/%b at %0t",
                             tg, dout_en, dout, e_en, e_val, $time);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_pin(bit en, bit val, string tag);
        q_en.push_back(en);
        q_val.push_back(val);
        q_tag.push_back(tag);
        ->smp_ev;
        tick(1);
    endtask

    function automatic int alen();
        return wide ? 6 : 7;
    endfunction

    function automatic int dlen();
        return wide ? 16 : 8;
    endfunction

    task automatic clk_bit(bit b);
        di = b; tick(3);
        sk = 1'b1; tick(6);
        sk = 1'b0; tick(6);
    endtask

    task automatic sel();
        cs = 1'b1; tick(6);
    endtask

    task automatic desel();
        cs = 1'b0; di = 1'b0; tick(6);
    endtask

    task automatic send_head(bit [1:0] op, int addr);
        clk_bit(1'b1);
        clk_bit(op[1]);
        clk_bit(op[0]);
        for (int i = alen() - 1; i >= 0; i--) clk_bit(addr[i]);
    endtask

    task automatic send_data(logic [15:0] d);
        for (int i = dlen() - 1; i >= 0; i--) clk_bit(d[i]);
    endtask

    task automatic read_chk(int addr, logic [15:0] exp, int lead, string tag);
        sel();
        for (int i = 0; i < lead; i++) clk_bit(1'b0);
        send_head(2'b10, addr);
        expect_pin(1'b1, 1'b0, tag);              // dummy zero
        for (int i = dlen() - 1; i >= 0; i--) begin
            clk_bit(1'b0);
            expect_pin(1'b1, exp[i], tag);
        end
        desel();
        expect_pin(1'b0, 1'b0, "R1");
    endtask

    task automatic prog_write(int addr, logic [15:0] d);
        sel(); send_head(2'b01, addr); send_data(d); desel();
    endtask

    task automatic ext_cmd(bit [1:0] sub, logic [15:0] d, bit with_data);
        sel();
        send_head(2'b00, int'(sub) << (alen() - 2));
        if (with_data) send_data(d);
        desel();
    endtask

    task automatic status_cycle(string tag);
        sel();
        expect_pin(1'b1, 1'b0, tag);              // busy
        tick(PROG + 20);
        expect_pin(1'b1, 1'b1, tag);              // ready
        desel();
        expect_pin(1'b0, 1'b0, tag);
    endtask

    initial begin
        tick(4);
        rst = 1'b0;
        tick(4);
        expect_pin(1'b0, 1'b0, "R1");             // deselected after reset

        // R1 erased array, R3 read of it
        read_chk(5, 16'hFFFF, 0, "R1");

        // R7: programming before enable is ignored, no status either
        prog_write(5, 16'hA5C3);
        sel(); expect_pin(1'b0, 1'b0, "R7"); desel();
        read_chk(5, 16'hFFFF, 0, "R7");

        // R6 enable, then R4 write with R8/R9 status
        ext_cmd(2'b11, 16'h0, 1'b0);
        prog_write(5, 16'hA5C3);
        status_cycle("R9");
        read_chk(5, 16'hA5C3, 0, "R4");
        read_chk(5, 16'hA5C3, 2, "R2");           // leading zeros before start

        prog_write(63, 16'h1234);
        status_cycle("R8");
        read_chk(63, 16'h1234, 0, "R3");

        // R4 byte placement seen in byte mode
        wide = 1'b0; tick(4);
        read_chk(11, 16'h00A5, 0, "R4");
        read_chk(10, 16'h00C3, 0, "R4");
        read_chk(127, 16'h0012, 0, "R2");         // 7-bit address
        prog_write(0, 16'h005A);
        status_cycle("R9");
        read_chk(0, 16'h005A, 0, "R4");
        wide = 1'b1; tick(4);
        read_chk(0, 16'hFF5A, 0, "R4");

        // R5 erase one word, neighbour untouched
        sel(); send_head(2'b11, 5); desel();
        status_cycle("R8");
        read_chk(5, 16'hFFFF, 0, "R5");
        read_chk(63, 16'h1234, 0, "R5");

        // R9 no status when selected after the interval
        sel(); send_head(2'b11, 62); desel();
        tick(PROG + 100);
        sel(); expect_pin(1'b0, 1'b0, "R9"); desel();

        // R10 frame during busy is dropped
        prog_write(7, 16'h0BAD);
        sel();
        expect_pin(1'b1, 1'b0, "R9");
        send_head(2'b01, 8);
        send_data(16'hBEEF);
        desel();
        tick(PROG + 50);
        read_chk(8, 16'hFFFF, 0, "R10");
        read_chk(7, 16'h0BAD, 0, "R10");

        // R6 fill with data, then fill with ones
        ext_cmd(2'b01, 16'h3C96, 1'b1);
        status_cycle("R8");
        read_chk(0, 16'h3C96, 0, "R6");
        read_chk(63, 16'h3C96, 0, "R6");
        ext_cmd(2'b10, 16'h0, 1'b0);
        status_cycle("R8");
        read_chk(33, 16'hFFFF, 0, "R6");

        // R7 disable stops programming; R3 reads still work
        prog_write(2, 16'h1111);
        status_cycle("R9");
        ext_cmd(2'b00, 16'h0, 1'b0);
        prog_write(3, 16'h2222);
        sel(); expect_pin(1'b0, 1'b0, "R7"); desel();
        read_chk(3, 16'hFFFF, 0, "R7");
        read_chk(2, 16'h1111, 0, "R3");

        tick(4);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule